// File: doc/BRIEF.md
# Prioritized Interrupt and Pin Controller

This block collects fifteen active-low interrupt lines, masks them with a software-programmed enable vector and reports the most urgent one. It gives a single request flag and a 4-bit level code naming the winning line. Lines 1 to 15 share their pads with a 16-pin parallel port. Once software drives a pin as an output, that pin stops feeding the interrupt logic, and reading it back returns the value being driven. Interrupt line 3 can be handed over to an external timer. While the timer is enabled, its pending flag stands in for the pad.

Software talks to the block one bit at a time. A write carries a 5-bit address and one data bit, and a read returns one bit a cycle later. Address 0 selects between interrupt mode and clock mode. Addresses 1 to 15 edit the enable mask in interrupt mode. In clock mode, writing 0 to address 15 wipes the whole mask. Addresses 16 to 31 address port pins 0 to 15.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After the synchronous reset, `irq` is 0, `level` is 0, every pin is an input (`pin_oe` all 0), `pin_out` is all 0, the mask is empty and the block is in interrupt mode (a read of address 0 returns 0).
- R2: At every clock edge, line k (1..15) is recorded as active when `pin_in[k]` is 0 and pin k is an input. A line whose pin is an output is recorded as inactive, whatever its pad level.
- R3: While `timer_en` is 1, line 3 is recorded as active exactly when `timer_pend` is 1, and `pin_in[3]` has no effect.
- R4: The recorded lines are ANDed with the mask. The lowest-numbered surviving line is output as `level`, its number in binary, two clock edges after the input change.
- R5: `irq` is 1 only when at least one enabled line is active. When none is, `irq` is 0 and `level` is 0.
- R6: Driving a pin as an output, at either value, never raises `irq`.
- R7: A write to address 16+k sets `pin_out[k]` to the data bit and sets `pin_oe[k]` to 1 at the next edge.
- R8: A read of address 16+k returns `pin_out[k]` if pin k is an output and `pin_in[k]` otherwise.
- R9: A write to address 0 selects clock mode with data 1 and interrupt mode with data 0. A read of address 0 returns the current mode.
- R10: In interrupt mode, a write to address k (1..15) sets mask bit k to the data bit, and `irq`/`level` follow from the new mask.
- R11: In clock mode, writing 0 to address 15 clears every mask bit. Other clock-mode writes to addresses 1..15 leave the mask unchanged.
- R12: A read of address k (1..15) returns 1 when line k is currently recorded as active, before masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bit write strobe |
| wr_addr | input | 5 | Bit address of the write |
| wr_bit | input | 1 | Data bit of the write |
| rd_addr | input | 5 | Bit address of the read |
| rd_bit | output | 1 | Registered read data, valid one cycle after `rd_addr` |
| pin_in | input | 16 | Pad levels; bits 1..15 are also the active-low interrupt lines |
| pin_out | output | 16 | Values driven onto pins configured as outputs |
| pin_oe | output | 16 | Per-pin output enable (1 = output) |
| timer_en | input | 1 | Hands interrupt line 3 to the timer |
| timer_pend | input | 1 | Timer pending flag |
| irq | output | 1 | Interrupt request |
| level | output | 4 | Number of the winning line, 0 when none |

## Verification
The assertions assume that pads and the timer flags change only between clock edges, and that a write and a read are each held for exactly one cycle. The bench meets this by changing every input at the falling edge. The request and level checks assume inputs settle before sampling, so the bench waits three falling edges after any stimulus, which is longer than the two-register path from pad to `level`. Each scenario starts from a fresh reset, so pin directions left behind by one task cannot mask lines in the next.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
  localparam int unsigned NUM_LINES = 15;
  localparam int unsigned PORT_W    = 16;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned LVL_W     = 4;
  localparam int unsigned TMR_LINE  = 3;

  typedef enum logic {MODE_INT = 1'b0, MODE_CLK = 1'b1} ctl_mode_e;
endpackage

// File: rtl/prio_irq_port.sv
`timescale 1ns/1ps
module prio_irq_port #(
  parameter int unsigned PW = 16,
  localparam int unsigned IW = $clog2(PW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic          wval,
  input  logic [IW-1:0] ridx,
  input  logic [PW-1:0] pads,
  output logic [PW-1:0] drv,
  output logic [PW-1:0] oe,
  output logic          rval
);
  logic [PW-1:0] drv_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= '0;
      oe_q  <= '0;
    end else if (we) begin
      drv_q[widx] <= wval;
      oe_q[widx]  <= 1'b1;
    end
  end

  assign rval = oe_q[ridx] ? drv_q[ridx] : pads[ridx];
  assign drv  = drv_q;
  assign oe   = oe_q;
endmodule

// File: rtl/prio_irq_ctl.sv
`timescale 1ns/1ps
module prio_irq_ctl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NL = 15,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic          wval,
  output ctl_mode_e     mode,
  output logic [NL:1]   mask
);
  ctl_mode_e   mode_q;
  logic [NL:1] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_INT;
      mask_q <= '0;
    end else if (we) begin
      if (widx == '0) begin
        mode_q <= ctl_mode_e'(wval);
      end else if (mode_q == MODE_INT) begin
        for (int i = 1; i <= NL; i++)
          if (widx == IW'(i)) mask_q[i] <= wval;
      end else if (widx == IW'(NL) && !wval) begin
        mask_q <= '0;
      end
    end
  end

  assign mode = mode_q;
  assign mask = mask_q;
endmodule

// File: rtl/prio_irq_gather.sv
`timescale 1ns/1ps
module prio_irq_gather #(
  parameter int unsigned NL = 15,
  parameter int unsigned TL = 3,
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL:1]   line_n,
  input  logic [NL:1]   is_out,
  input  logic          tmr_en,
  input  logic          tmr_pend,
  input  logic [NL:1]   mask,
  output logic [NL:1]   act,
  output logic          req,
  output logic [LW-1:0] lvl
);
  logic [NL:1]   act_q;
  logic [NL:1]   hot;
  logic [LW-1:0] win;
  logic          req_q;
  logic [LW-1:0] lvl_q;

  for (genvar g = 1; g <= NL; g++) begin : g_line
    if (g == TL) begin : g_tmr
      always_ff @(posedge clk) begin
        if (rst)         act_q[g] <= 1'b0;
        else if (tmr_en) act_q[g] <= tmr_pend;
        else             act_q[g] <= ~is_out[g] & ~line_n[g];
      end
    end else begin : g_pad
      always_ff @(posedge clk) begin
        if (rst) act_q[g] <= 1'b0;
        else     act_q[g] <= ~is_out[g] & ~line_n[g];
      end
    end
  end

  assign hot = act_q & mask;

  always_comb begin
    win = '0;
    for (int i = NL; i >= 1; i--)
      if (hot[i]) win = LW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      lvl_q <= '0;
    end else begin
      req_q <= |hot;
      lvl_q <= win;
    end
  end

  assign act = act_q;
  assign req = req_q;
  assign lvl = lvl_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NL = NUM_LINES,
  parameter int unsigned PW = PORT_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned LW = LVL_W,
  parameter int unsigned TL = TMR_LINE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit,
  input  logic [PW-1:0] pin_in,
  output logic [PW-1:0] pin_out,
  output logic [PW-1:0] pin_oe,
  input  logic          timer_en,
  input  logic          timer_pend,
  output logic          irq,
  output logic [LW-1:0] level
);
  localparam int unsigned IW = AW - 1;

  logic          wr_pin, wr_ctl;
  logic [IW-1:0] widx, ridx;
  logic          port_rval;
  ctl_mode_e     mode_w;
  logic [NL:1]   mask_w;
  logic [NL:1]   act_w;
  logic          rd_q;
  logic          rd_nxt;

  assign wr_pin = wr_en &  wr_addr[AW-1];
  assign wr_ctl = wr_en & ~wr_addr[AW-1];
  assign widx   = wr_addr[IW-1:0];
  assign ridx   = rd_addr[IW-1:0];

  prio_irq_port #(.PW(PW)) u_port (
    .clk(clk), .rst(rst), .we(wr_pin), .widx(widx), .wval(wr_bit),
    .ridx(ridx), .pads(pin_in), .drv(pin_out), .oe(pin_oe), .rval(port_rval)
  );

  prio_irq_ctl #(.NL(NL), .IW(IW)) u_ctl (
    .clk(clk), .rst(rst), .we(wr_ctl), .widx(widx), .wval(wr_bit),
    .mode(mode_w), .mask(mask_w)
  );

  prio_irq_gather #(.NL(NL), .TL(TL), .LW(LW)) u_gather (
    .clk(clk), .rst(rst), .line_n(pin_in[NL:1]), .is_out(pin_oe[NL:1]),
    .tmr_en(timer_en), .tmr_pend(timer_pend), .mask(mask_w),
    .act(act_w), .req(irq), .lvl(level)
  );

  always_comb begin
    rd_nxt = 1'b0;
    if (rd_addr[AW-1]) begin
      rd_nxt = port_rval;
    end else if (ridx == '0) begin
      rd_nxt = (mode_w == MODE_CLK);
    end else begin
      for (int i = 1; i <= NL; i++)
        if (ridx == IW'(i)) rd_nxt = act_w[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_nxt;
  end

  assign rd_bit = rd_q;
endmodule

// File: rtl/prio_irq_chk.sv
`timescale 1ns/1ps
module prio_irq_chk
  import prio_irq_pkg::*;
#(
  parameter int unsigned NL = NUM_LINES,
  parameter int unsigned PW = PORT_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned LW = LVL_W,
  parameter int unsigned TL = TMR_LINE
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          wr_bit,
  input logic [AW-1:0] rd_addr,
  input logic          rd_bit,
  input logic [PW-1:0] pin_out,
  input logic [PW-1:0] pin_oe,
  input logic          timer_en,
  input logic          irq,
  input logic [LW-1:0] level,
  input logic [NL:1]   act,
  input logic [NL:1]   mask,
  input ctl_mode_e     mode
);
  logic [NL:1] oe_d;
  logic [NL:1] exempt;

  always_ff @(posedge clk) begin
    oe_d   <= pin_oe[NL:1];
    exempt <= '0;
    exempt[TL] <= timer_en;
  end

  AST_OUT_LINE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (act & oe_d & ~exempt) == '0); // R2

  AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (rst)
    irq |-> level != '0); // R4

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !irq |-> level == '0); // R5

  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (|(act & mask)) |=> irq); // R5

  AST_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !(|(act & mask)) |=> !irq); // R5

  AST_PIN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[AW-1]) |=>
      (pin_oe[$past(wr_addr[AW-2:0])] &&
       pin_out[$past(wr_addr[AW-2:0])] == $past(wr_bit))); // R7

  AST_RD_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (rd_addr[AW-1] && pin_oe[rd_addr[AW-2:0]]) |=>
      rd_bit == $past(pin_out[rd_addr[AW-2:0]])); // R8

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0) |=> mode == ctl_mode_e'($past(wr_bit))); // R9

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == MODE_CLK && wr_addr == AW'(NL) && !wr_bit) |=>
      mask == '0); // R11
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NL(NL), .PW(PW), .AW(AW), .LW(LW), .TL(TL)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
  .rd_addr(rd_addr), .rd_bit(rd_bit), .pin_out(pin_out), .pin_oe(pin_oe),
  .timer_en(timer_en), .irq(irq), .level(level), .act(act_w),
  .mask(mask_w), .mode(mode_w)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic        wr_bit = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic        rd_bit;
  logic [15:0] pin_in = 16'hFFFF;
  logic [15:0] pin_out, pin_oe;
  logic        timer_en = 1'b0;
  logic        timer_pend = 1'b0;
  logic        irq;
  logic [3:0]  level;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_bit(wr_bit),
    .rd_addr(rd_addr), .rd_bit(rd_bit), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .timer_en(timer_en), .timer_pend(timer_pend),
    .irq(irq), .level(level)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; pin_in = 16'hFFFF; timer_en = 1'b0; timer_pend = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic b);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_bit = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_bit;
  endtask

  task automatic t_reset();
    logic v;
    do_reset();
    chk("R1 irq", irq, 0);
    chk("R1 level", level, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);
    rd(5'd0, v);
    chk("R1 mode", v, 0);
    pin_in[6] = 1'b0; settle();
    chk("R1 mask empty", irq, 0);
  endtask

  task automatic t_priority();
    do_reset();
    wr(5'd5, 1'b1); wr(5'd9, 1'b1);
    pin_in[9] = 1'b0; settle();
    chk("R2 line9 irq", irq, 1);
    chk("R4 level9", level, 9);
    pin_in[5] = 1'b0; settle();
    chk("R4 lowest wins", level, 5);
    pin_in[2] = 1'b0; settle();
    chk("R4 disabled line2", level, 5);
    wr(5'd5, 1'b0); settle();
    chk("R10 clear bit5", level, 9);
    pin_in = 16'hFFFF; settle();
    chk("R5 no irq", irq, 0);
    chk("R5 level zero", level, 0);
  endtask

  task automatic t_readback();
    logic v;
    do_reset();
    pin_in[7] = 1'b0; settle();
    rd(5'd7, v);
    chk("R12 line7 active", v, 1);
    rd(5'd6, v);
    chk("R12 line6 idle", v, 0);
    chk("R12 unmasked no irq", irq, 0);
  endtask

  task automatic t_timer();
    do_reset();
    wr(5'd3, 1'b1);
    pin_in[3] = 1'b0; settle();
    chk("R2 pad3 level", level, 3);
    timer_en = 1'b1; timer_pend = 1'b0; settle();
    chk("R3 pad ignored", irq, 0);
    pin_in[3] = 1'b1; timer_pend = 1'b1; settle();
    chk("R3 timer irq", irq, 1);
    chk("R3 timer level", level, 3);
  endtask

  task automatic t_pins();
    logic v;
    do_reset();
    wr(5'd4, 1'b1);
    pin_in[4] = 1'b1;
    wr(5'd20, 1'b0);
    chk("R7 oe4", pin_oe[4], 1);
    chk("R7 out4", pin_out[4], 0);
    settle();
    chk("R6 output low no irq", irq, 0);
    pin_in[4] = 1'b0; settle();
    chk("R2 output pad ignored", irq, 0);
    pin_in[4] = 1'b1;
    rd(5'd20, v);
    chk("R8 driven 0", v, 0);
    wr(5'd20, 1'b1);
    pin_in[4] = 1'b0;
    rd(5'd20, v);
    chk("R8 driven 1", v, 1);
    settle();
    chk("R6 output high no irq", irq, 0);
    pin_in[6] = 1'b0;
    rd(5'd22, v);
    chk("R8 input pad", v, 0);
    chk("R7 pin6 still input", pin_oe[6], 0);
  endtask

  task automatic t_mode();
    logic v;
    do_reset();
    wr(5'd5, 1'b1);
    pin_in[5] = 1'b0; settle();
    chk("R10 irq on", irq, 1);
    wr(5'd0, 1'b1);
    rd(5'd0, v);
    chk("R9 clock mode", v, 1);
    wr(5'd5, 1'b0); settle();
    chk("R11 clock write kept", irq, 1);
    wr(5'd15, 1'b1); settle();
    chk("R11 write 1 kept", irq, 1);
    wr(5'd15, 1'b0); settle();
    chk("R11 soft clear", irq, 0);
    wr(5'd0, 1'b0);
    rd(5'd0, v);
    chk("R9 interrupt mode", v, 0);
    wr(5'd5, 1'b1); settle();
    chk("R10 re-enable", level, 5);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_priority();
    t_readback();
    t_timer();
    t_pins();
    t_mode();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule